// File: doc/BRIEF.md
# Interlaced SD Video Timing Generator

The block produces the raster timing for standard-definition interlaced video in one of two formats. Format 0 is 720x480 interlaced at 60 Hz and format 1 is 720x576 interlaced at 50 Hz. Both run from a 27 MHz pixel clock. It drives active-low horizontal and vertical sync, a display-enable, a field flag, and the column and frame-line coordinates of the pixel being shown. A downstream pixel source uses these to fetch character or pixel data. Each active pixel lasts two clocks, so 720 pixels fill 1440 clocks of a line. A frame is made of two fields. Field 0 comes first. The vertical sync of field 1 starts and ends half a line later than the sync of field 0. The Y output is the line's row in the full interleaved frame.

The design is built around three enumerated state machines. The line machine steps through H_ACTIVE, H_FRONT, H_SYNC and H_BACK. It moves H_ACTIVE to H_FRONT after the last active clock, H_FRONT to H_SYNC at the start of sync, H_SYNC to H_BACK at the end of sync, and H_BACK to H_ACTIVE at the end of the line. The field machine steps through V_ACTIVE, V_FRONT, V_SYNC and V_BACK. Its transitions occur only at line ends: V_ACTIVE to V_FRONT after the last active line, V_FRONT to V_SYNC before the first sync line, V_SYNC to V_BACK after the last sync line, and V_BACK to V_ACTIVE at the end of the field. The field flag toggles at that last transition. A format register reloads from `mode_sel` when the block leaves reset and at the end of each field 1. A format change therefore never lands mid-frame. All timing values are parameters. The figures below use the defaults.

Top module: `sd_interlace_timing`

## Requirements
- R1: On the clock edge that samples `rst` high, the block restarts at field 0, line 0, clock 0 and takes its format from `mode_sel` (0 = 480i, 1 = 576i). In that state `de` is 1, `pix_x` and `pix_y` are 0, and both syncs are high.
- R2: A line lasts 1716 clocks in format 0 and 1728 clocks in format 1. On active lines `de` is high for line clocks 0 to 1439 only.
- R3: While `de` is high, `pix_x` equals the line clock divided by two. Each of the 720 pixels is therefore held for two clocks.
- R4: `hsync_n` is low for line clocks 1478 to 1601 in format 0 and 1464 to 1589 in format 1. It is high on every other clock, on every line.
- R5: Field 0 has 263 lines (format 0) or 313 lines (format 1). Field 1 has 262 or 312 lines. `field` reads 0 then 1 and changes only at the first clock of a field.
- R6: Lines 0 to 239 (format 0) or 0 to 287 (format 1) of each field are active. While `de` is high, `pix_y` = 2 x line-in-field + `field`.
- R7: In field 0, `vsync_n` is low on whole lines 243 to 245 (format 0) or 290 to 292 (format 1), from clock 0 of the first of these lines.
- R8: In field 1, `vsync_n` goes low at clock 858 (format 0) or 864 (format 1) of line 243 or 290. It goes high at that same clock of line 246 or 293.
- R9: While `de` is low, `pix_x` and `pix_y` are 0.
- R10: A change of `mode_sel` takes effect only on the clock edge that ends the last line of field 1. The format in force is the value sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (27 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Requested format: 0 = 480i60, 1 = 576i50 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low, half-line offset in field 1 |
| de | output | 1 | High while the current clock is a visible pixel |
| field | output | 1 | 0 during the first field of a frame, 1 during the second |
| pix_x | output | XW (10) | Active pixel column, 0 when `de` is low |
| pix_y | output | YW (10) | Active frame line (interleaved), 0 when `de` is low |

## Verification
Every output is decoded from state that updates on the same clock edge as the counters. So after a reset edge or any clock edge, the outputs already describe the new raster position, with no pipeline delay. `mode_sel` is read only on the edge that closes a frame. The first clock of the next frame runs in the new format. The bench drives and samples on the falling edge. For each sample it computes the expected raster position by dividing a count of clocks since the frame start by the line length. That count advances by one for each rising edge. On the frame-wrap edge the bench takes the value of `mode_sel` held at that edge. The bench uses a reduced parameter set so that whole frames of both formats, format switches in both directions, and resets in mid-frame are all checked on every clock.

// File: rtl/sd_timing_pkg.sv
package sd_timing_pkg;

    typedef enum logic [1:0] {
        H_ACTIVE,
        H_FRONT,
        H_SYNC,
        H_BACK
    } hstate_e;

    typedef enum logic [1:0] {
        V_ACTIVE,
        V_FRONT,
        V_SYNC,
        V_BACK
    } vstate_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sd_mode_latch.sv
module sd_mode_latch #(
    parameter int PIX_SHIFT   = 1,
    parameter int M0_H_ACT    = 720,
    parameter int M0_H_FP     = 38,
    parameter int M0_H_SYNC   = 124,
    parameter int M0_H_TOT    = 1716,
    parameter int M0_V_ACT    = 240,
    parameter int M0_V_FP     = 3,
    parameter int M0_V_SYNC   = 3,
    parameter int M0_F0_LINES = 263,
    parameter int M0_F1_LINES = 262,
    parameter int M1_H_ACT    = 720,
    parameter int M1_H_FP     = 24,
    parameter int M1_H_SYNC   = 126,
    parameter int M1_H_TOT    = 1728,
    parameter int M1_V_ACT    = 288,
    parameter int M1_V_FP     = 2,
    parameter int M1_V_SYNC   = 3,
    parameter int M1_F0_LINES = 313,
    parameter int M1_F1_LINES = 312,
    parameter int HW          = 11,
    parameter int LW          = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_sel,
    input  logic          frame_end,
    output logic          mode_q,
    output logic [HW-1:0] act_clks,
    output logic [HW-1:0] hs_start,
    output logic [HW-1:0] hs_end,
    output logic [HW-1:0] htot,
    output logic [HW-1:0] half,
    output logic [LW-1:0] v_act,
    output logic [LW-1:0] vs_start,
    output logic [LW-1:0] vs_end,
    output logic [LW-1:0] f0_lines,
    output logic [LW-1:0] f1_lines
);

    localparam int ACT_T  [2] = '{M0_H_ACT << PIX_SHIFT, M1_H_ACT << PIX_SHIFT};
    localparam int HSS_T  [2] = '{(M0_H_ACT << PIX_SHIFT) + M0_H_FP,
                                  (M1_H_ACT << PIX_SHIFT) + M1_H_FP};
    localparam int HSE_T  [2] = '{(M0_H_ACT << PIX_SHIFT) + M0_H_FP + M0_H_SYNC,
                                  (M1_H_ACT << PIX_SHIFT) + M1_H_FP + M1_H_SYNC};
    localparam int TOT_T  [2] = '{M0_H_TOT, M1_H_TOT};
    localparam int HALF_T [2] = '{M0_H_TOT / 2, M1_H_TOT / 2};
    localparam int VACT_T [2] = '{M0_V_ACT, M1_V_ACT};
    localparam int VSS_T  [2] = '{M0_V_ACT + M0_V_FP, M1_V_ACT + M1_V_FP};
    localparam int VSE_T  [2] = '{M0_V_ACT + M0_V_FP + M0_V_SYNC,
                                  M1_V_ACT + M1_V_FP + M1_V_SYNC};
    localparam int F0_T   [2] = '{M0_F0_LINES, M1_F0_LINES};
    localparam int F1_T   [2] = '{M0_F1_LINES, M1_F1_LINES};

    // Format register: loaded at reset and at the close of every frame
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            mode_q <= mode_sel;
        end
    end

    always_comb begin
        act_clks = HW'(ACT_T[mode_q]);
        hs_start = HW'(HSS_T[mode_q]);
        hs_end   = HW'(HSE_T[mode_q]);
        htot     = HW'(TOT_T[mode_q]);
        half     = HW'(HALF_T[mode_q]);
        v_act    = LW'(VACT_T[mode_q]);
        vs_start = LW'(VSS_T[mode_q]);
        vs_end   = LW'(VSE_T[mode_q]);
        f0_lines = LW'(F0_T[mode_q]);
        f1_lines = LW'(F1_T[mode_q]);
    end

endmodule

// File: rtl/sd_line_fsm.sv
module sd_line_fsm
    import sd_timing_pkg::*;
#(
    parameter int HW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] act_clks,
    input  logic [HW-1:0] hs_start,
    input  logic [HW-1:0] hs_end,
    input  logic [HW-1:0] htot,
    input  logic [HW-1:0] half,
    output logic [HW-1:0] hcnt,
    output logic          h_active,
    output logic          hsync_act,
    output logic          line_end,
    output logic          half_pt
);

    hstate_e state_q, state_d;

    assign line_end = (hcnt == htot - 1'b1);
    assign half_pt  = (hcnt == half - 1'b1);

    // State register and clock-in-line counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= H_ACTIVE;
            hcnt    <= '0;
        end else begin
            state_q <= state_d;
            hcnt    <= line_end ? '0 : hcnt + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_ACTIVE: if (hcnt == act_clks - 1'b1) state_d = H_FRONT;
            H_FRONT:  if (hcnt == hs_start - 1'b1) state_d = H_SYNC;
            H_SYNC:   if (hcnt == hs_end - 1'b1)   state_d = H_BACK;
            H_BACK:   if (line_end)                state_d = H_ACTIVE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        h_active  = 1'b0;
        hsync_act = 1'b0;
        unique case (state_q)
            H_ACTIVE: h_active  = 1'b1;
            H_SYNC:   hsync_act = 1'b1;
            H_FRONT,
            H_BACK:   ;
        endcase
    end

endmodule

// File: rtl/sd_field_fsm.sv
module sd_field_fsm
    import sd_timing_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic          half_pt,
    input  logic [LW-1:0] v_act,
    input  logic [LW-1:0] vs_start,
    input  logic [LW-1:0] vs_end,
    input  logic [LW-1:0] f0_lines,
    input  logic [LW-1:0] f1_lines,
    output logic [LW-1:0] lcnt,
    output logic          field,
    output logic          v_active,
    output logic          vsync_act,
    output logic          frame_end
);

    vstate_e     state_q, state_d;
    logic        field_end;
    logic [LW-1:0] last_line;
    logic        vs_q;

    assign last_line = field ? f1_lines - 1'b1 : f0_lines - 1'b1;
    assign field_end = line_end && (lcnt == last_line);
    assign frame_end = field_end && field;

    // State register, line counter and field flag
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= V_ACTIVE;
            lcnt    <= '0;
            field   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (field_end) begin
                lcnt  <= '0;
                field <= ~field;
            end else if (line_end) begin
                lcnt <= lcnt + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (line_end) begin
            unique case (state_q)
                V_ACTIVE: if (lcnt == v_act - 1'b1)    state_d = V_FRONT;
                V_FRONT:  if (lcnt == vs_start - 1'b1) state_d = V_SYNC;
                V_SYNC:   if (lcnt == vs_end - 1'b1)   state_d = V_BACK;
                V_BACK:   if (field_end)               state_d = V_ACTIVE;
            endcase
        end
    end

    // Vertical sync: whole lines in field 0, shifted by half a line in field 1
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b0;
        end else if (line_end && !field) begin
            if (lcnt == vs_start - 1'b1)    vs_q <= 1'b1;
            else if (lcnt == vs_end - 1'b1) vs_q <= 1'b0;
        end else if (half_pt && field) begin
            if (lcnt == vs_start)    vs_q <= 1'b1;
            else if (lcnt == vs_end) vs_q <= 1'b0;
        end
    end

    always_comb begin
        v_active = 1'b0;
        unique case (state_q)
            V_ACTIVE: v_active = 1'b1;
            V_FRONT,
            V_SYNC,
            V_BACK:   ;
        endcase
        vsync_act = vs_q;
    end

endmodule

// File: rtl/sd_interlace_timing.sv
module sd_interlace_timing
    import sd_timing_pkg::*;
#(
    parameter int PIX_SHIFT   = 1,
    parameter int M0_H_ACT    = 720,
    parameter int M0_H_FP     = 38,
    parameter int M0_H_SYNC   = 124,
    parameter int M0_H_TOT    = 1716,
    parameter int M0_V_ACT    = 240,
    parameter int M0_V_FP     = 3,
    parameter int M0_V_SYNC   = 3,
    parameter int M0_F0_LINES = 263,
    parameter int M0_F1_LINES = 262,
    parameter int M1_H_ACT    = 720,
    parameter int M1_H_FP     = 24,
    parameter int M1_H_SYNC   = 126,
    parameter int M1_H_TOT    = 1728,
    parameter int M1_V_ACT    = 288,
    parameter int M1_V_FP     = 2,
    parameter int M1_V_SYNC   = 3,
    parameter int M1_F0_LINES = 313,
    parameter int M1_F1_LINES = 312,
    parameter int HW = $clog2(imax(M0_H_TOT, M1_H_TOT)),
    parameter int LW = $clog2(imax(M0_F0_LINES, M1_F0_LINES)),
    parameter int XW = $clog2(imax(M0_H_ACT, M1_H_ACT)),
    parameter int YW = $clog2(imax(M0_V_ACT, M1_V_ACT)) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_sel,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic          field,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y
);

    logic          mode_q;
    logic [HW-1:0] act_clks, hs_start, hs_end, htot, half, hcnt, xs;
    logic [LW-1:0] v_act, vs_start, vs_end, f0_lines, f1_lines, lcnt;
    logic          h_active, hsync_act, line_end, half_pt;
    logic          v_active, vsync_act, frame_end;

    sd_mode_latch #(
        .PIX_SHIFT(PIX_SHIFT),
        .M0_H_ACT(M0_H_ACT), .M0_H_FP(M0_H_FP), .M0_H_SYNC(M0_H_SYNC), .M0_H_TOT(M0_H_TOT),
        .M0_V_ACT(M0_V_ACT), .M0_V_FP(M0_V_FP), .M0_V_SYNC(M0_V_SYNC),
        .M0_F0_LINES(M0_F0_LINES), .M0_F1_LINES(M0_F1_LINES),
        .M1_H_ACT(M1_H_ACT), .M1_H_FP(M1_H_FP), .M1_H_SYNC(M1_H_SYNC), .M1_H_TOT(M1_H_TOT),
        .M1_V_ACT(M1_V_ACT), .M1_V_FP(M1_V_FP), .M1_V_SYNC(M1_V_SYNC),
        .M1_F0_LINES(M1_F0_LINES), .M1_F1_LINES(M1_F1_LINES),
        .HW(HW), .LW(LW)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .frame_end(frame_end),
        .mode_q   (mode_q),
        .act_clks (act_clks),
        .hs_start (hs_start),
        .hs_end   (hs_end),
        .htot     (htot),
        .half     (half),
        .v_act    (v_act),
        .vs_start (vs_start),
        .vs_end   (vs_end),
        .f0_lines (f0_lines),
        .f1_lines (f1_lines)
    );

    sd_line_fsm #(.HW(HW)) u_line (
        .clk      (clk),
        .rst      (rst),
        .act_clks (act_clks),
        .hs_start (hs_start),
        .hs_end   (hs_end),
        .htot     (htot),
        .half     (half),
        .hcnt     (hcnt),
        .h_active (h_active),
        .hsync_act(hsync_act),
        .line_end (line_end),
        .half_pt  (half_pt)
    );

    sd_field_fsm #(.LW(LW)) u_field (
        .clk      (clk),
        .rst      (rst),
        .line_end (line_end),
        .half_pt  (half_pt),
        .v_act    (v_act),
        .vs_start (vs_start),
        .vs_end   (vs_end),
        .f0_lines (f0_lines),
        .f1_lines (f1_lines),
        .lcnt     (lcnt),
        .field    (field),
        .v_active (v_active),
        .vsync_act(vsync_act),
        .frame_end(frame_end)
    );

    assign xs = hcnt >> PIX_SHIFT;

    always_comb begin
        de      = h_active && v_active;
        hsync_n = ~hsync_act;
        vsync_n = ~vsync_act;
        pix_x   = de ? xs[XW-1:0] : '0;
        pix_y   = de ? {lcnt[YW-2:0], field} : '0;
    end

endmodule

// File: rtl/sd_timing_chk.sv
module sd_timing_chk #(
    parameter int HW = 11,
    parameter int LW = 9,
    parameter int XW = 10,
    parameter int YW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          de,
    input logic          field,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y,
    input logic [HW-1:0] hcnt,
    input logic [HW-1:0] half,
    input logic [LW-1:0] lcnt,
    input logic          mode_q
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R4
    hsync_idle_in_active_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> hsync_n);

    // R9
    blank_coords_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (pix_x == '0 && pix_y == '0));

    // R6
    y_parity_field_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> (pix_y[0] == field));

    // R5
    field_flip_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && !$stable(field)) |-> (hcnt == '0 && lcnt == '0));

    // R10
    mode_flip_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && !$stable(mode_q)) |-> (hcnt == '0 && lcnt == '0 && !field));

    // R7
    vsync_even_start_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && $fell(vsync_n) && !field) |-> (hcnt == '0));

    // R8
    vsync_odd_start_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && $fell(vsync_n) && field) |-> (hcnt == half));

    // R8
    vsync_odd_end_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && $rose(vsync_n) && field) |-> (hcnt == half));

endmodule

bind sd_interlace_timing sd_timing_chk #(
    .HW(HW), .LW(LW), .XW(XW), .YW(YW)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .hsync_n(hsync_n),
    .vsync_n(vsync_n),
    .de     (de),
    .field  (field),
    .pix_x  (pix_x),
    .pix_y  (pix_y),
    .hcnt   (hcnt),
    .half   (half),
    .lcnt   (lcnt),
    .mode_q (mode_q)
);

// File: tb/sd_interlace_timing_bench.sv
module sd_interlace_timing_bench;
    import sd_timing_pkg::*;

    localparam int PS = 1;
    localparam int A0_HACT = 6, A0_HFP = 2, A0_HSY = 3, A0_HTOT = 20;
    localparam int A0_VACT = 4, A0_VFP = 1, A0_VSY = 2, A0_F0 = 9, A0_F1 = 8;
    localparam int A1_HACT = 8, A1_HFP = 2, A1_HSY = 4, A1_HTOT = 26;
    localparam int A1_VACT = 5, A1_VFP = 2, A1_VSY = 2, A1_F0 = 11, A1_F1 = 10;
    localparam int XW = $clog2(imax(A0_HACT, A1_HACT));
    localparam int YW = $clog2(imax(A0_VACT, A1_VACT)) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_sel = 1'b0;
    logic          hsync_n, vsync_n, de, field;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;

    int checks = 0;
    int errors = 0;
    int emode  = 0;
    int fpos   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sd_interlace_timing #(
        .PIX_SHIFT(PS),
        .M0_H_ACT(A0_HACT), .M0_H_FP(A0_HFP), .M0_H_SYNC(A0_HSY), .M0_H_TOT(A0_HTOT),
        .M0_V_ACT(A0_VACT), .M0_V_FP(A0_VFP), .M0_V_SYNC(A0_VSY),
        .M0_F0_LINES(A0_F0), .M0_F1_LINES(A0_F1),
        .M1_H_ACT(A1_HACT), .M1_H_FP(A1_HFP), .M1_H_SYNC(A1_HSY), .M1_H_TOT(A1_HTOT),
        .M1_V_ACT(A1_VACT), .M1_V_FP(A1_VFP), .M1_V_SYNC(A1_VSY),
        .M1_F0_LINES(A1_F0), .M1_F1_LINES(A1_F1)
    ) u_sd_interlace_timing (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .field(field),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    function automatic int p_htot(int m); return m ? A1_HTOT : A0_HTOT; endfunction
    function automatic int p_hact(int m); return m ? A1_HACT : A0_HACT; endfunction
    function automatic int p_hfp(int m);  return m ? A1_HFP  : A0_HFP;  endfunction
    function automatic int p_hsy(int m);  return m ? A1_HSY  : A0_HSY;  endfunction
    function automatic int p_vact(int m); return m ? A1_VACT : A0_VACT; endfunction
    function automatic int p_vfp(int m);  return m ? A1_VFP  : A0_VFP;  endfunction
    function automatic int p_vsy(int m);  return m ? A1_VSY  : A0_VSY;  endfunction
    function automatic int p_f0(int m);   return m ? A1_F0   : A0_F0;   endfunction
    function automatic int p_f1(int m);   return m ? A1_F1   : A0_F1;   endfunction

    task automatic cmp(string req, string ph, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0t: got %0d expected %0d", req, ph, $time, got, exp);
        end
    endtask

    task automatic check_now(string ph);
        int ht, f, l, h, p, vs0, ha;
        int e_de, e_x, e_y, e_hs, e_vs;
        ht = p_htot(emode);
        if (fpos < p_f0(emode) * ht) begin
            f = 0; l = fpos / ht; h = fpos % ht;
        end else begin
            p = fpos - p_f0(emode) * ht;
            f = 1; l = p / ht; h = p % ht;
        end
        ha   = p_hact(emode) << PS;
        e_de = (h < ha && l < p_vact(emode)) ? 1 : 0;
        e_x  = e_de ? (h >> PS) : 0;
        e_y  = e_de ? (2 * l + f) : 0;
        e_hs = (h >= ha + p_hfp(emode) && h < ha + p_hfp(emode) + p_hsy(emode)) ? 0 : 1;
        vs0  = p_vact(emode) + p_vfp(emode);
        if (f == 0) begin
            e_vs = (l >= vs0 && l < vs0 + p_vsy(emode)) ? 0 : 1;
        end else begin
            p    = l * ht + h;
            e_vs = (p >= vs0 * ht + ht / 2 && p < (vs0 + p_vsy(emode)) * ht + ht / 2) ? 0 : 1;
        end
        cmp("R2 de", ph, int'(de), e_de);
        cmp("R5 field", ph, int'(field), f);
        cmp("R4 hsync_n", ph, int'(hsync_n), e_hs);
        cmp(f ? "R8 vsync_n" : "R7 vsync_n", ph, int'(vsync_n), e_vs);
        cmp(e_de ? "R3 pix_x" : "R9 pix_x", ph, int'(pix_x), e_x);
        cmp(e_de ? "R6 pix_y" : "R9 pix_y", ph, int'(pix_y), e_y);
    endtask

    // Check the present position, then step the model over the coming rising edge
    task automatic run(int n, string ph);
        for (int i = 0; i < n; i++) begin
            check_now(ph);
            if (fpos == (p_f0(emode) + p_f1(emode)) * p_htot(emode) - 1) begin
                fpos  = 0;
                emode = int'(mode_sel);
            end else begin
                fpos++;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_reset(int m);
        rst      = 1'b1;
        mode_sel = m[0];
        @(negedge clk);
        rst   = 1'b0;
        fpos  = 0;
        emode = m;
    endtask

    localparam int FR0 = (A0_F0 + A0_F1) * A0_HTOT;
    localparam int FR1 = (A1_F0 + A1_F1) * A1_HTOT;

    initial begin
        @(negedge clk);
        do_reset(0);
        run(1, "R1 origin after reset fmt0");
        run(149, "R1 fmt0 first frame");
        mode_sel = 1'b1;
        run(FR0 - 150, "R10 request fmt1 mid-frame");
        run(2 * FR1, "R10 fmt1 frames");
        run(200, "R10 fmt1 before request");
        mode_sel = 1'b0;
        run(FR1 - 200, "R10 request fmt0 mid-frame");
        run(FR0 + 77, "R2 fmt0 steady");
        do_reset(1);
        run(1, "R1 origin after reset fmt1");
        run(FR1 + 31, "R1 fmt1 after mid-frame reset");
        do_reset(0);
        run(FR0, "R1 fmt0 after reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule